// File: doc/BRIEF.md
# Paged Command and Interrupt Register Core

This block is the host-facing control core of a network controller. The host sees a byte-wide window of 16 offsets. A two-bit page field in the command byte decides which of three register pages the window shows. At many page-0 offsets a read and a write reach different registers: a read returns a status byte that the datapath engines supply, and a write stores a configuration byte. Page 2 reads those configuration bytes back. Page 1 is a plain bank of read/write bytes for the station address, the current receive page and the multicast hash.

The core owns the command byte, which holds the stop, start, transmit-request, remote-DMA and page fields. It also owns the interrupt status and mask bytes and the interrupt line. The engines report events to it through single-cycle pulses, through a busy level and through the top bits of their three error tally counters. In return the core drives the online, transmit-request and remote-DMA command levels to the engines. Reads are combinational from the current address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `nic_page_regs`

## Requirements
- R1: After reset the command byte reads 0x21 (stop=1, start=0, DMA field 100, page 0), the status byte reads 0x80, the mask reads 0x00, and irq, online and txReq are 0.
- R2: Bits 7:6 of the command byte select the page (00 page 0, 01 page 1, 10 page 2, 11 reserved). Offset 0 reads and writes the command byte on every page.
- R3: On page 0, writes to offsets 1–6 and 8–14 store configuration bytes. Reads at every offset except 0, 3 (boundary byte, read/write) and 7 (status) return engRdData. Page 2 returns the bytes written at page-0 offsets 1, 2, 4, 12, 13 and 14 at the same offsets, and the mask at offset 15. Its other offsets read 0.
- R4: On page 1, offsets 1–15 are independent read/write bytes.
- R5: When the stop bit (bit 0) is 1 and busy is low at a clock edge, the reset-status bit (status bit 7) is 1 from that edge onward. While busy stays high the bit stays clear.
- R6: A command write with start (bit 1) = 1 and stop = 0 clears status bit 7 at that edge. This clear takes priority over the set in R5. online equals start AND NOT stop.
- R7: A command write with bit 2 = 1 sets txReq. Writing 0 there leaves txReq unchanged. A txOk or txErr pulse clears it unless a write sets it in the same cycle.
- R8: The remote-DMA field (bits 5:3) takes the written value, except that a write of 000 leaves it unchanged. A DMA-done pulse sets the field to 100 (abort/idle) and sets status bit 6.
- R9: Each event pulse sets its status bit at the next edge: rxOk bit 0, txOk bit 1, rxErr bit 2, txErr bit 3, overwrite bit 4. Writing 1 to a status bit at page-0 offset 7 clears it, and writing 0 leaves it. A set wins over a clear in the same cycle. Writes never change bit 7.
- R10: Status bit 5 is set when any bit of tallyMsb rises from 0 to 1. A bit that stays high does not set it again.
- R11: The mask is written at page-0 offset 15. Its bit 7 always reads 0. irq is registered: it equals the OR of (status AND mask) as it stood one edge earlier.
- R12: Page 3 (reserved) reads 0 at offsets 1–15 and ignores writes there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Window offset for reads and writes |
| regWr | input | 1 | Write strobe, one byte per cycle |
| regWrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for regAddr on the current page |
| engRdData | input | 8 | Status byte supplied by the engines for page-0 status offsets |
| busy | input | 1 | A frame is in progress; delays the stop handshake |
| evRxOk | input | 1 | Pulse: frame received without error |
| evTxOk | input | 1 | Pulse: frame transmitted |
| evRxErr | input | 1 | Pulse: receive error |
| evTxErr | input | 1 | Pulse: transmit error or abort |
| evOverwrite | input | 1 | Pulse: receive ring overwrite |
| evDmaDone | input | 1 | Pulse: remote DMA complete |
| tallyMsb | input | 3 | Top bits of the three error tally counters |
| irq | output | 1 | Registered interrupt request |
| online | output | 1 | Controller started and not stopped |
| txReq | output | 1 | Transmit request bit of the command byte |
| dmaCmd | output | 3 | Remote-DMA command field |

## Verification
A register write or an event pulse that is sampled at clock edge k is visible on rdData, online, txReq and dmaCmd immediately after edge k. irq follows one edge later, at k+1. The stop handshake needs the stop bit to be registered at edge k and busy to be low at a later edge. The bench drives every input on the falling edge and samples on the falling edge right after the edge that matters. For irq it samples after both k and k+1, so that both the lag and the final value are checked. It sweeps all four pages, all fifteen page-1 bytes, each event source, and the same-cycle priority cases.

// File: rtl/nicreg_pkg.sv
package nicreg_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int NUM_OFF = 1 << ADDR_W;
  localparam int TALLY_N = 3;
  localparam int PAGE_LO = 6;

  // fixed window offsets that the control decodes itself
  localparam logic [ADDR_W-1:0] OFF_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_BND  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(NUM_OFF - 1);

  localparam logic [DATA_W-1:0] CMD_RESET = 8'h21;
  localparam logic [2:0]        DMA_IDLE  = 3'b100;

  typedef struct packed {
    logic              cfgWr;
    logic              pg1Wr;
    logic [ADDR_W-1:0] off;
    logic [DATA_W-1:0] data;
  } regStrobe_t;
endpackage

// File: rtl/nicreg_ctrl.sv
module nicreg_ctrl
  import nicreg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              busy,
  input  logic              evRxOk,
  input  logic              evTxOk,
  input  logic              evRxErr,
  input  logic              evTxErr,
  input  logic              evOverwrite,
  input  logic              evDmaDone,
  input  logic [TALLY_N-1:0] tallyMsb,
  output logic [DATA_W-1:0] crQ,
  output logic [DATA_W-1:0] isrQ,
  output logic [DATA_W-1:0] imrQ,
  output regStrobe_t        strobe,
  output logic              irq
);
  logic [1:0]         page;
  logic               crWr, isrWr, imrWr, startCmd;
  logic [DATA_W-1:0]  crNext;
  logic [DATA_W-2:0]  isrLo, setV, clrV;
  logic               rstStat, cntRise;
  logic [TALLY_N-1:0] tallyPrev;

  assign page     = crQ[PAGE_LO +: 2];
  assign crWr     = regWr && (regAddr == OFF_CMD);
  assign isrWr    = regWr && (page == 2'd0) && (regAddr == OFF_STAT);
  assign imrWr    = regWr && (page == 2'd0) && (regAddr == OFF_MASK);
  assign startCmd = crWr && regWrData[1] && !regWrData[0];
  assign cntRise  = |(tallyMsb & ~tallyPrev);

  // strobes towards the datapath byte store
  always_comb begin
    strobe.off   = regAddr;
    strobe.data  = regWrData;
    strobe.cfgWr = regWr && (page == 2'd0) && (regAddr != OFF_CMD) &&
                   (regAddr != OFF_STAT) && (regAddr != OFF_MASK);
    strobe.pg1Wr = regWr && (page == 2'd1) && (regAddr != OFF_CMD);
  end

  always_comb begin
    crNext = crQ;
    if (evTxOk || evTxErr) crNext[2] = 1'b0;
    if (evDmaDone)         crNext[5:3] = DMA_IDLE;
    if (crWr) begin
      crNext[7:6] = regWrData[7:6];
      crNext[1:0] = regWrData[1:0];
      if (regWrData[2])           crNext[2]   = 1'b1;
      if (regWrData[5:3] != 3'b0) crNext[5:3] = regWrData[5:3];
    end
  end

  assign setV = {evDmaDone, cntRise, evOverwrite, evTxErr, evRxErr, evTxOk, evRxOk};
  assign clrV = isrWr ? regWrData[DATA_W-2:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crQ       <= CMD_RESET;
      isrLo     <= '0;
      rstStat   <= 1'b1;
      imrQ      <= '0;
      tallyPrev <= '0;
      irq       <= 1'b0;
    end else begin
      crQ       <= crNext;
      isrLo     <= (isrLo & ~clrV) | setV;
      tallyPrev <= tallyMsb;
      irq       <= |(isrQ & imrQ);
      if (startCmd)               rstStat <= 1'b0;
      else if (crQ[0] && !busy)   rstStat <= 1'b1;
      if (imrWr) imrQ <= {1'b0, regWrData[DATA_W-2:0]};
    end
  end

  assign isrQ = {rstStat, isrLo};
endmodule

// File: rtl/nicreg_dp.sv
module nicreg_dp
  import nicreg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] engRdData,
  input  logic [DATA_W-1:0] crQ,
  input  logic [DATA_W-1:0] isrQ,
  input  logic [DATA_W-1:0] imrQ,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] cfgRegs [1:NUM_OFF-1];
  logic [DATA_W-1:0] pg1Regs [1:NUM_OFF-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 1; i < NUM_OFF; i++) begin
        cfgRegs[i] <= '0;
        pg1Regs[i] <= '0;
      end
    end else begin
      for (int i = 1; i < NUM_OFF; i++) begin
        if (strobe.cfgWr && strobe.off == ADDR_W'(i)) cfgRegs[i] <= strobe.data;
        if (strobe.pg1Wr && strobe.off == ADDR_W'(i)) pg1Regs[i] <= strobe.data;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (regAddr == OFF_CMD) rdData = crQ;
    else begin
      unique case (crQ[PAGE_LO +: 2])
        2'd0: begin
          if (regAddr == OFF_BND)       rdData = cfgRegs[OFF_BND];
          else if (regAddr == OFF_STAT) rdData = isrQ;
          else                          rdData = engRdData;
        end
        2'd1: rdData = pg1Regs[regAddr];
        2'd2: begin
          case (regAddr)
            4'd1, 4'd2, 4'd4, 4'd12, 4'd13, 4'd14: rdData = cfgRegs[regAddr];
            OFF_MASK: rdData = imrQ;
            default:  rdData = '0;
          endcase
        end
        default: rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/nic_page_regs.sv
module nic_page_regs
  import nicreg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [DATA_W-1:0]  engRdData,
  input  logic               busy,
  input  logic               evRxOk,
  input  logic               evTxOk,
  input  logic               evRxErr,
  input  logic               evTxErr,
  input  logic               evOverwrite,
  input  logic               evDmaDone,
  input  logic [TALLY_N-1:0] tallyMsb,
  output logic               irq,
  output logic               online,
  output logic               txReq,
  output logic [2:0]         dmaCmd
);
  logic [DATA_W-1:0] crQ, isrQ, imrQ;
  regStrobe_t        strobe;

  nicreg_ctrl u_ctrl (
    .clk, .rstN, .regAddr, .regWr, .regWrData, .busy,
    .evRxOk, .evTxOk, .evRxErr, .evTxErr, .evOverwrite, .evDmaDone,
    .tallyMsb, .crQ, .isrQ, .imrQ, .strobe, .irq
  );

  nicreg_dp u_dp (
    .clk, .rstN, .strobe, .regAddr, .engRdData, .crQ, .isrQ, .imrQ, .rdData
  );

  assign online = crQ[1] & ~crQ[0];
  assign txReq  = crQ[2];
  assign dmaCmd = crQ[5:3];
endmodule

// File: rtl/nicreg_chk.sv
module nicreg_chk
  import nicreg_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWr,
  input logic [DATA_W-1:0]  regWrData,
  input logic               busy,
  input logic               evRxOk,
  input logic               evTxOk,
  input logic               evTxErr,
  input logic [TALLY_N-1:0] tallyMsb,
  input logic               txReq,
  input logic               irq,
  input logic [DATA_W-1:0]  crQ,
  input logic [DATA_W-1:0]  isrQ,
  input logic [DATA_W-1:0]  imrQ
);
  logic cmdWr;
  assign cmdWr = regWr && (regAddr == OFF_CMD);

  // R5
  stop_sets_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (crQ[0] && !busy && !(cmdWr && regWrData[1] && !regWrData[0])) |=> isrQ[7]);

  // R6
  start_clears_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && regWrData[1] && !regWrData[0]) |=> !isrQ[7]);

  // R7
  tx_done_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((evTxOk || evTxErr) && !(cmdWr && regWrData[2])) |=> !txReq);

  // R9
  rx_event_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    evRxOk |=> isrQ[0]);

  // R10
  tally_rise_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(tallyMsb & ~$past(tallyMsb))) |=> isrQ[5]);

  // R11
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irq == (|($past(isrQ) & $past(imrQ)))));
endmodule

bind nic_page_regs nicreg_chk u_chk (
  .clk, .rstN, .regAddr, .regWr, .regWrData, .busy,
  .evRxOk, .evTxOk, .evTxErr, .tallyMsb, .txReq, .irq,
  .crQ(crQ), .isrQ(isrQ), .imrQ(imrQ)
);

// File: tb/nic_page_regs_tb.sv
module nic_page_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] regAddr;
  logic       regWr;
  logic [7:0] regWrData, rdData, engRdData;
  logic       busy;
  logic [5:0] evs;
  logic [2:0] tallyMsb;
  logic       irq, online, txReq;
  logic [2:0] dmaCmd;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_page_regs u_dut (
    .clk, .rstN, .regAddr, .regWr, .regWrData, .rdData, .engRdData, .busy,
    .evRxOk(evs[0]), .evTxOk(evs[1]), .evRxErr(evs[2]), .evTxErr(evs[3]),
    .evOverwrite(evs[4]), .evDmaDone(evs[5]),
    .tallyMsb, .irq, .online, .txReq, .dmaCmd
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    chk(tag, rdData, exp);
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    evs[idx] = 1'b1;
    @(negedge clk);
    evs = '0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
  end

  initial begin
    rstN = 1'b0; regAddr = '0; regWr = 1'b0; regWrData = '0;
    engRdData = 8'hC3; busy = 1'b0; evs = '0; tallyMsb = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdChk("R1 cmd", 4'd0, 8'h21);
    rdChk("R1 status", 4'd7, 8'h80);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 online", {7'b0, online}, 8'h00);
    chk("R1 txReq", {7'b0, txReq}, 8'h00);

    // R6 start clears reset status, online follows
    wr(4'd0, 8'h22);
    rdChk("R6 status", 4'd7, 8'h00);
    chk("R6 online", {7'b0, online}, 8'h01);

    // R2 page select sweep, command at offset 0 on every page
    for (int p = 0; p < 4; p++) begin
      wr(4'd0, {p[1:0], 6'b100010});
      rdChk("R2 cmd page", 4'd0, {p[1:0], 6'b100010});
    end

    // R4 page-1 bank sweep
    wr(4'd0, 8'h62);
    for (int o = 1; o < 16; o++) wr(o[3:0], 8'(o * 17) ^ 8'h5A);
    for (int o = 1; o < 16; o++) rdChk("R4 pg1", o[3:0], 8'(o * 17) ^ 8'h5A);

    // R3 page-0 split meanings
    wr(4'd0, 8'h22);
    rdChk("R3 bnd untouched by pg1", 4'd3, 8'h00);
    for (int o = 1; o < 15; o++) if (o != 7) wr(o[3:0], 8'(o + 8'h30));
    rdChk("R3 bnd rw", 4'd3, 8'h33);
    rdChk("R3 off4 status", 4'd4, 8'hC3);
    engRdData = 8'h5E;
    rdChk("R3 off12 status", 4'd12, 8'h5E);
    wr(4'd0, 8'hA2);
    rdChk("R3 pg2 off1", 4'd1, 8'h31);
    rdChk("R3 pg2 off2", 4'd2, 8'h32);
    rdChk("R3 pg2 off4", 4'd4, 8'h34);
    rdChk("R3 pg2 off12", 4'd12, 8'h3C);
    rdChk("R3 pg2 off13", 4'd13, 8'h3D);
    rdChk("R3 pg2 off14", 4'd14, 8'h3E);
    rdChk("R3 pg2 off3", 4'd3, 8'h00);

    // R12 reserved page
    wr(4'd0, 8'hE2);
    wr(4'd4, 8'hFF);
    for (int o = 1; o < 16; o++) rdChk("R12 pg3 read", o[3:0], 8'h00);
    wr(4'd0, 8'hA2);
    rdChk("R12 write ignored", 4'd4, 8'h34);

    // R9 event sweep with mask zero
    wr(4'd0, 8'h22);
    for (int i = 0; i < 5; i++) begin
      pulse(i);
      rdChk("R9 event bit", 4'd7, 8'(1 << i));
      chk("R11 masked irq", {7'b0, irq}, 8'h00);
      wr(4'd7, 8'h7F);
    end
    rdChk("R9 w1c", 4'd7, 8'h00);

    // R8 DMA field and done event
    wr(4'd0, 8'h0A);
    chk("R8 dma read cmd", {5'b0, dmaCmd}, 8'h01);
    wr(4'd0, 8'h02);
    chk("R8 zero keeps", {5'b0, dmaCmd}, 8'h01);
    pulse(5);
    chk("R8 done idles", {5'b0, dmaCmd}, 8'h04);
    rdChk("R8 done status", 4'd7, 8'h40);
    wr(4'd7, 8'h40);

    // R9 set wins over clear; partial clear
    @(negedge clk);
    evs[0] = 1'b1; regAddr = 4'd7; regWrData = 8'h01; regWr = 1'b1;
    @(negedge clk);
    evs = '0; regWr = 1'b0;
    rdChk("R9 set wins", 4'd7, 8'h01);
    pulse(2);
    wr(4'd7, 8'h01);
    rdChk("R9 clear only ones", 4'd7, 8'h04);
    wr(4'd7, 8'h04);

    // R10 tally rise
    @(negedge clk); tallyMsb = 3'b010;
    @(negedge clk);
    rdChk("R10 rise", 4'd7, 8'h20);
    wr(4'd7, 8'h20);
    @(negedge clk);
    rdChk("R10 held no reset", 4'd7, 8'h00);
    tallyMsb = 3'b110;
    @(negedge clk);
    rdChk("R10 second rise", 4'd7, 8'h20);
    wr(4'd7, 8'h20);

    // R11 mask and irq lag
    wr(4'd15, 8'hFF);
    wr(4'd0, 8'hA2);
    rdChk("R11 mask bit7", 4'd15, 8'h7F);
    wr(4'd0, 8'h22);
    pulse(3);
    chk("R11 irq lag", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R11 irq", {7'b0, irq}, 8'h01);
    wr(4'd7, 8'h08);
    @(negedge clk);
    chk("R11 irq drop", {7'b0, irq}, 8'h00);

    // R7 transmit request
    wr(4'd0, 8'h26);
    chk("R7 set", {7'b0, txReq}, 8'h01);
    wr(4'd0, 8'h22);
    chk("R7 zero keeps", {7'b0, txReq}, 8'h01);
    pulse(1);
    chk("R7 ok clears", {7'b0, txReq}, 8'h00);
    wr(4'd0, 8'h26);
    pulse(3);
    chk("R7 err clears", {7'b0, txReq}, 8'h00);
    wr(4'd7, 8'h0A);

    // R5 stop handshake waits for busy
    busy = 1'b1;
    wr(4'd0, 8'h21);
    chk("R6 offline", {7'b0, online}, 8'h00);
    repeat (3) @(negedge clk);
    rdChk("R5 held while busy", 4'd7, 8'h00);
    busy = 1'b0;
    @(negedge clk);
    rdChk("R5 set", 4'd7, 8'h80);
    chk("R11 bit7 no irq", {7'b0, irq}, 8'h00);
    wr(4'd7, 8'h80);
    rdChk("R9 bit7 ignores write", 4'd7, 8'h80);
    wr(4'd0, 8'h22);
    rdChk("R6 restart", 4'd7, 8'h00);

    summary();
  end
endmodule